// File: doc/BRIEF.md
# I2C Master Address Phase Sequencer

This block runs the addressing part of an I2C master transfer. Software loads two address byte registers. A pulse on `start` then makes the block serialise one or more address bytes onto SDA, MSB first. It places one bit per SCL-low strobe and releases the line for the acknowledge slot. The parent transaction controller owns the SCL waveform, the data phase, arbitration and clock stretching. That controller supplies the strobes, and it receives `done`, `nack` and the resolved transfer direction.

The block selects the addressing mode from the first register. When that register's upper five bits hold the reserved 10-bit tag 11110, the block sends a two-byte address: the first register with its direction bit cleared, then the second register. If the requested direction (bit 0 of the first register) is read, the block then raises a repeated-start request. After the parent acknowledges that request, the block sends the first byte again with bit 0 set. Any other value of the first register is sent alone, as a 7-bit address followed by its direction bit. Both registers are copied when a transfer starts, so writes made during a transfer affect only the next one.

Top module: `i2c_addr_seq`

## Requirements
- R1: Two address registers are selected by `reg_sel` (0 = first, 1 = second). Each stores bits [7:0] of `reg_wdata` when `reg_we` is high. Each reads back on `reg_rdata` with bits [15:8] zero, and both reset to zero.
- R2: When bits [7:3] of the first register are not 11110, a transfer sends that register unchanged as a single byte. `rd_dir` then equals its bit 0 (1 = read).
- R3: When bits [7:3] of the first register are 11110 and bit 0 is 0, the block sends the first register and then the second register. `rd_dir` is 0.
- R4: When bits [7:3] of the first register are 11110 and bit 0 is 1, the block sends the first register with bit 0 cleared, then the second register. It then holds `rstart_req` high until `rstart_ack` arrives. After that it sends the first register with bit 0 set, and `rd_dir` is 1.
- R5: Within a byte, each `scl_low_stb` puts the next bit on `sda_out`, MSB first, one cycle later. The ninth strobe releases `sda_out` to 1. `sda_out` changes only in the cycle after a low strobe.
- R6: In the acknowledge slot, `sda_in` is sampled on `scl_high_stb`. A high level ends the sequence with `done` and `nack` both asserted, and no further byte is sent.
- R7: `done` is a one-cycle pulse, asserted in the cycle after the last acknowledge is sampled. `busy` falls in the following cycle.
- R8: `start` is ignored while `busy` is high. A register write during a transfer does not change the bits being sent.
- R9: While idle, `sda_out` is 1 (released) and `rstart_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 first byte, 1 second byte |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |
| start | input | 1 | Begin an address phase (taken when idle) |
| busy | output | 1 | Sequence in progress |
| scl_low_stb | input | 1 | One-cycle strobe while SCL is low: shift point |
| scl_high_stb | input | 1 | One-cycle strobe while SCL is high: sample point |
| sda_in | input | 1 | Sampled SDA line level |
| sda_out | output | 1 | SDA drive level, 1 = released |
| rstart_req | output | 1 | Repeated start needed before the read byte |
| rstart_ack | input | 1 | Parent has issued the repeated start |
| done | output | 1 | One-cycle end-of-phase pulse |
| nack | output | 1 | With `done`: the slave did not acknowledge |
| rd_dir | output | 1 | Resolved direction, 1 = read |

## Verification
The assertions assume that the parent never asserts both strobes in the same cycle. They also assume that the parent issues `scl_high_stb` only after the low strobe that released SDA, and that it raises `rstart_ack` only while `rstart_req` is high. The directed tasks keep to these rules. Each strobe is a single-cycle pulse separated from the next by an idle cycle, the acknowledge level is applied together with its high strobe, and the restart acknowledge is sent only after the bench has seen the request.

// File: rtl/i2c_addr_pkg.sv
// Shared types for the I2C address phase sequencer.
// Assumes an 8-bit address byte where the 10-bit tag sits in the top 5 bits.
package i2c_addr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_RSTART,
        ST_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_HEAD,
        PH_LOW,
        PH_HEAD_RD
    } phase_t;

    localparam int TAG_W = 5;
    localparam logic [TAG_W-1:0] TENBIT_TAG = 5'b11110;
endpackage

// File: rtl/i2c_addr_regs.sv
// Holds the two address byte registers for the sequencer.
// Only the low BYTE_W bits of a write are stored; the upper bus bits read as zero.
module i2c_addr_regs #(
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic [BYTE_W-1:0] head_q,
    output logic [BYTE_W-1:0] low_q
);
    localparam int NREG = 2;
    localparam int PAD_W = BUS_W - BYTE_W;

    logic [BYTE_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Store the low byte of a write aimed at this register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (int'(sel) == g))
                regs[g] <= wdata[BYTE_W-1:0];
        end
    end

    // Return the selected register, zero-extended onto the bus.
    always_comb rdata = {{PAD_W{1'b0}}, regs[sel]};

    assign head_q = regs[0];
    assign low_q  = regs[1];
endmodule

// File: rtl/i2c_addr_planner.sv
// Chooses the byte to send for the current phase and what follows it.
// Assumes head/low are a stable snapshot taken at transfer start.
module i2c_addr_planner #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]  head,
    input  logic [BYTE_W-1:0]  low,
    input  i2c_addr_pkg::phase_t phase,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               want_rd,
    output logic               last,
    output logic               need_rstart
);
    import i2c_addr_pkg::*;

    logic ten_bit;

    // Decode the mode and the per-phase byte and successor.
    always_comb begin
        ten_bit     = (head[BYTE_W-1 -: TAG_W] == TENBIT_TAG);
        want_rd     = head[0];
        tx_byte     = head;
        last        = 1'b1;
        need_rstart = 1'b0;
        case (phase)
            PH_HEAD: begin
                tx_byte = ten_bit ? {head[BYTE_W-1:1], 1'b0} : head;
                last    = !ten_bit;
            end
            PH_LOW: begin
                tx_byte     = low;
                last        = !want_rd;
                need_rstart = want_rd;
            end
            PH_HEAD_RD: begin
                tx_byte = {head[BYTE_W-1:1], 1'b1};
                last    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_addr_seq.sv
// Address phase sequencer for an I2C master.
// Serialises 7-bit or 10-bit address bytes MSB first on SCL-low strobes and
// samples ACK on SCL-high strobes. Assumes the parent never raises both
// strobes together and supplies SCL timing, restarts and the data phase.
module i2c_addr_seq #(
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             start,
    output logic             busy,
    input  logic             scl_low_stb,
    input  logic             scl_high_stb,
    input  logic             sda_in,
    output logic             sda_out,
    output logic             rstart_req,
    input  logic             rstart_ack,
    output logic             done,
    output logic             nack,
    output logic             rd_dir
);
    import i2c_addr_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    seq_state_t        state;
    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] head_s, low_s, head_r, low_r;
    logic [BYTE_W-1:0] tx_byte;
    logic              want_rd, last, need_rstart;
    logic              sda_q, nack_q, dir_q;

    i2c_addr_regs #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .head_q (head_r),
        .low_q  (low_r)
    );

    i2c_addr_planner #(.BYTE_W(BYTE_W)) u_plan (
        .head        (head_s),
        .low         (low_s),
        .phase       (phase),
        .tx_byte     (tx_byte),
        .want_rd     (want_rd),
        .last        (last),
        .need_rstart (need_rstart)
    );

    // Sequence the bytes, shift bits and evaluate each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_HEAD;
            bit_cnt <= '0;
            shreg   <= '0;
            head_s  <= '0;
            low_s   <= '0;
            sda_q   <= 1'b1;
            nack_q  <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        head_s  <= head_r;
                        low_s   <= low_r;
                        dir_q   <= head_r[0];
                        nack_q  <= 1'b0;
                        phase   <= PH_HEAD;
                        bit_cnt <= '0;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (scl_low_stb) begin
                        if (bit_cnt == ACK_SLOT) begin
                            sda_q <= 1'b1;
                            state <= ST_ACK;
                        end else if (bit_cnt == '0) begin
                            sda_q   <= tx_byte[BYTE_W-1];
                            shreg   <= {tx_byte[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            sda_q   <= shreg[BYTE_W-1];
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_high_stb) begin
                        bit_cnt <= '0;
                        if (sda_in) begin
                            nack_q <= 1'b1;
                            state  <= ST_FIN;
                        end else if (last) begin
                            state <= ST_FIN;
                        end else if (need_rstart) begin
                            phase <= PH_HEAD_RD;
                            state <= ST_RSTART;
                        end else begin
                            phase <= PH_LOW;
                            state <= ST_SHIFT;
                        end
                    end
                end
                ST_RSTART: begin
                    if (rstart_ack) state <= ST_SHIFT;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the status outputs from the sequence state.
    always_comb begin
        busy       = (state != ST_IDLE);
        rstart_req = (state == ST_RSTART);
        done       = (state == ST_FIN);
        nack       = done && nack_q;
        sda_out    = sda_q;
        rd_dir     = dir_q;
    end
endmodule

// File: rtl/i2c_addr_seq_chk.sv
// Protocol checker for the address phase sequencer, bound to every instance.
// Assumes the parent drives single-cycle, non-overlapping strobes.
module i2c_addr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_low_stb,
    input logic scl_high_stb,
    input logic busy,
    input logic sda_out,
    input logic rstart_req,
    input logic done,
    input logic nack
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(scl_high_stb));

    assert_nack_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nack |-> done);

    assert_sda_moves_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_out) |-> $past(scl_low_stb));

    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sda_out && !rstart_req));

    assert_restart_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_req |-> (busy && sda_out));
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_low_stb  (scl_low_stb),
    .scl_high_stb (scl_high_stb),
    .busy         (busy),
    .sda_out      (sda_out),
    .rstart_req   (rstart_req),
    .done         (done),
    .nack         (nack)
);

// File: tb/tb_i2c_addr_seq.sv
// Directed bench for the address phase sequencer: one task per scenario.
module tb_i2c_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        start = 1'b0, busy;
    logic        scl_low_stb = 1'b0, scl_high_stb = 1'b0, sda_in = 1'b1;
    logic        sda_out, rstart_req, done, nack, rd_dir;
    logic        rstart_ack = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    i2c_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start), .busy(busy),
        .scl_low_stb(scl_low_stb), .scl_high_stb(scl_high_stb), .sda_in(sda_in),
        .sda_out(sda_out), .rstart_req(rstart_req), .rstart_ack(rstart_ack),
        .done(done), .nack(nack), .rd_dir(rd_dir)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] val);
        @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic low_stb();
        @(negedge clk); scl_low_stb = 1'b1;
        @(negedge clk); scl_low_stb = 1'b0;
    endtask

    // Apply the acknowledge level with a high strobe; sample one cycle later.
    task automatic high_stb(input logic ackv);
        @(negedge clk); scl_high_stb = 1'b1; sda_in = ackv;
        @(negedge clk); scl_high_stb = 1'b0; sda_in = 1'b1;
    endtask

    // Eight data bits MSB first, then the released acknowledge slot (R5).
    task automatic expect_byte(input logic [7:0] exp, input string req);
        logic [7:0] got = '0;
        for (int i = 7; i >= 0; i--) begin
            low_stb();
            got[i] = sda_out;
        end
        chk(got == exp, req, {8'h0, got}, {8'h0, exp});
        low_stb();
        chk(sda_out == 1'b1, "R5 ack slot released", {15'h0, sda_out}, 16'h1);
    endtask

    task automatic expect_done(input logic exp_nack, input logic exp_dir, input string req);
        chk(done == 1'b1, {req, " done"}, {15'h0, done}, 16'h1);
        chk(nack == exp_nack, {req, " nack"}, {15'h0, nack}, {15'h0, exp_nack});
        chk(rd_dir == exp_dir, {req, " rd_dir"}, {15'h0, rd_dir}, {15'h0, exp_dir});
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", {15'h0, done}, 16'h0);
        chk(busy == 1'b0, "R7 busy falls", {15'h0, busy}, 16'h0);
        chk(sda_out == 1'b1, "R9 idle released", {15'h0, sda_out}, 16'h1);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0 && rstart_req == 1'b0, "R9 reset idle", {13'h0, busy, done, rstart_req}, 16'h0);
        chk(sda_out == 1'b1, "R9 reset sda", {15'h0, sda_out}, 16'h1);
        reg_sel = 1'b0; #1;
        chk(reg_rdata == 16'h0, "R1 reset reg0", reg_rdata, 16'h0);
        reg_sel = 1'b1; #1;
        chk(reg_rdata == 16'h0, "R1 reset reg1", reg_rdata, 16'h0);
    endtask

    task automatic t_regs();
        wr_reg(1'b0, 16'h5A96);
        wr_reg(1'b1, 16'hABCD);
        reg_sel = 1'b0; #1;
        chk(reg_rdata == 16'h0096, "R1 reg0 readback", reg_rdata, 16'h0096);
        reg_sel = 1'b1; #1;
        chk(reg_rdata == 16'h00CD, "R1 reg1 readback", reg_rdata, 16'h00CD);
    endtask

    task automatic t_seven(input logic [7:0] head);
        wr_reg(1'b0, {8'h0, head});
        pulse_start();
        chk(busy == 1'b1, "R2 busy after start", {15'h0, busy}, 16'h1);
        expect_byte(head, "R2 seven-bit byte");
        high_stb(1'b0);
        expect_done(1'b0, head[0], "R2 R7");
    endtask

    task automatic t_ten_write();
        wr_reg(1'b0, 16'h00F2);
        wr_reg(1'b1, 16'h00A5);
        pulse_start();
        expect_byte(8'hF2, "R3 first byte");
        high_stb(1'b0);
        chk(done == 1'b0 && busy == 1'b1, "R3 continues", {14'h0, done, busy}, 16'h1);
        expect_byte(8'hA5, "R3 second byte");
        high_stb(1'b0);
        expect_done(1'b0, 1'b0, "R3");
    endtask

    task automatic t_ten_read();
        wr_reg(1'b0, 16'h00F5);
        wr_reg(1'b1, 16'h003C);
        pulse_start();
        expect_byte(8'hF4, "R4 first byte bit0 cleared");
        high_stb(1'b0);
        expect_byte(8'h3C, "R4 second byte");
        high_stb(1'b0);
        chk(rstart_req == 1'b1 && done == 1'b0, "R4 restart request", {14'h0, rstart_req, done}, 16'h2);
        low_stb();
        chk(rstart_req == 1'b1 && sda_out == 1'b1, "R4 waits for restart ack", {14'h0, rstart_req, sda_out}, 16'h3);
        @(negedge clk); rstart_ack = 1'b1;
        @(negedge clk); rstart_ack = 1'b0;
        chk(rstart_req == 1'b0, "R4 request cleared", {15'h0, rstart_req}, 16'h0);
        expect_byte(8'hF5, "R4 resend bit0 set");
        high_stb(1'b0);
        expect_done(1'b0, 1'b1, "R4");
    endtask

    task automatic t_nack();
        wr_reg(1'b0, 16'h00F0);
        pulse_start();
        expect_byte(8'hF0, "R6 byte before nack");
        high_stb(1'b1);
        expect_done(1'b1, 1'b0, "R6");
        low_stb();
        chk(sda_out == 1'b1 && busy == 1'b0, "R6 no further byte", {14'h0, sda_out, busy}, 16'h2);
    endtask

    task automatic t_busy_start();
        logic [7:0] got = '0;
        wr_reg(1'b0, 16'h00C3);
        pulse_start();
        for (int i = 7; i >= 4; i--) begin
            low_stb();
            got[i] = sda_out;
        end
        wr_reg(1'b0, 16'h003C);
        pulse_start();
        for (int i = 3; i >= 0; i--) begin
            low_stb();
            got[i] = sda_out;
        end
        chk(got == 8'hC3, "R8 snapshot and start ignored", {8'h0, got}, 16'h00C3);
        low_stb();
        high_stb(1'b0);
        expect_done(1'b0, 1'b1, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_seven(8'hA4);
        t_seven(8'h6B);
        t_ten_write();
        t_ten_read();
        t_nack();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule